// File: doc/BRIEF.md
# Configurable Adaptive Logic Element

This block models one programmable logic element of the kind found in a lookup-table fabric. It has eight data inputs and two 32-entry truth-table halves. The halves can be split or joined, two dedicated full adders sit behind them, and a pair of output registers can be linked to neighbouring elements through a register chain. A 2-bit mode field picks one of four uses:

- two independent functions, or one 6-input function;
- a 7-input function built from two 5-input functions and a multiplexer;
- a 2-bit adder whose operands come from four 4-input tables;
- one bit position of a carry-save multi-operand adder.

The element is programmed through a serial port. While the enable is high, a 70-bit frame is shifted in MSB first. During loading all outputs are forced to zero. Carry and shared-arithmetic chains run to the adjacent elements, so columns of elements can be stitched into wide adders.

Top module: `ale_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into a 70-bit frame. The first bit shifted ends up in frame bit 69. Frame bits [69:68] hold the mode (00 split/wide, 01 extended 7-input, 10 arithmetic, 11 shared arithmetic). Bits [67:64] hold the option bits opt[3:0]. Bits [63:32] hold the upper mask HI and bits [31:0] the lower mask LO.
- R2: While `cfg_en` is high, `comb0`, `comb1`, `carry_out` and `share_out` are 0, and every clock edge clears `q0` and `q1`.
- R3: In mode 00 with opt[2]=0, `comb0` = LO[d[4:0]] and `comb1` = HI[d[7:3]].
- R4: In mode 00 with opt[2]=1, `comb0` is the 64-entry function {HI,LO}[d[5:0]] and `comb1` is 0.
- R5: In mode 01, `comb0` = LO[d[4:0]] when d[7]=0 and HI[{d[6],d[3:0]}] when d[7]=1, and `comb1` is 0.
- R6: In mode 10, with a0=LO[d[3:0]], b0=LO[16+d[3:0]], a1=HI[d[7:4]], b1=HI[16+d[7:4]] and c the effective carry-in, {`carry_out`,`comb1`,`comb0`} = a0+b0+c+2·(a1+b1), and `share_out` is 0.
- R7: In both arithmetic modes, opt[3]=1 makes the effective carry-in 1 whatever `carry_in` is. Otherwise the effective carry-in equals `carry_in`.
- R8: In mode 11, with t=LO[d[2:0]] and k=HI[d[2:0]], {`carry_out`,`comb0`} = t + `share_in` + c, and `share_out` = `comb1` = k.
- R9: In modes 00 and 01, `carry_out` and `share_out` are 0.
- R10: On each edge with `rst` and `cfg_en` low, `q0` loads `chain_in` if opt[0]=1 and otherwise `comb0`. `q1` loads the previous `q0` if opt[1]=1 and otherwise `comb1`. `chain_out` equals `q1`.
- R11: A clock edge with `rst` high clears `q0`, `q1` and the whole configuration frame. The element then behaves as mode 00 with all-zero masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration bit, MSB first |
| d_in | input | 8 | Data inputs |
| carry_in | input | 1 | Carry chain input |
| carry_out | output | 1 | Carry chain output |
| share_in | input | 1 | Shared-arithmetic chain input |
| share_out | output | 1 | Shared-arithmetic chain output |
| chain_in | input | 1 | Register chain input |
| chain_out | output | 1 | Register chain output |
| comb0 | output | 1 | Combinational result 0 |
| comb1 | output | 1 | Combinational result 1 |
| q0 | output | 1 | Registered result 0 |
| q1 | output | 1 | Registered result 1 |

## Verification
The register-following properties assume the option bits cannot change under them. This holds because the frame only moves while `cfg_en` is high, and the properties are gated on `cfg_en` being low. The bench loads every configuration completely before it applies data, and it never toggles `cfg_en` in the middle of a data sequence. The adder property assumes the operand tables have settled in the same cycle as the data. The bench therefore changes `d_in`, `carry_in` and `share_in` only on falling edges, well away from the sampling edge.

// File: rtl/ale_pkg.sv
package ale_pkg;
  localparam int DIN_W   = 8;
  localparam int HALF_W  = 32;
  localparam int OPT_W   = 4;
  localparam int MODE_W  = 2;
  localparam int IDX5_W  = $clog2(HALF_W);
  localparam int IDX4_W  = IDX5_W - 1;
  localparam int IDX3_W  = IDX5_W - 2;
  localparam int FRAME_W = MODE_W + OPT_W + 2 * HALF_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_SPLIT  = 2'b00,
    MODE_EXT7   = 2'b01,
    MODE_ARITH  = 2'b10,
    MODE_SHARED = 2'b11
  } ale_mode_e;

  // field order is the shift order: first bit shifted lands in mode[1]
  typedef struct packed {
    ale_mode_e          mode;
    logic [OPT_W-1:0]   opt;
    logic [HALF_W-1:0]  hi;
    logic [HALF_W-1:0]  lo;
  } ale_cfg_t;

  // returns {carry, sum}
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
    full_add = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction
endpackage

// File: rtl/ale_cfg_shift.sv
module ale_cfg_shift
  import ale_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (rst)
      frame <= '0;
    else if (en)
      frame <= {frame[FRAME_W-2:0], din};
  end
endmodule

// File: rtl/ale_lut_half.sv
module ale_lut_half
  import ale_pkg::*;
(
  input  logic [HALF_W-1:0] mask,
  input  logic [IDX5_W-1:0] idx5,
  input  logic [IDX4_W-1:0] idx4,
  input  logic [IDX3_W-1:0] idx3,
  output logic              f5,
  output logic              op_a,
  output logic              op_b,
  output logic              f3
);
  assign f5   = mask[idx5];
  assign op_a = mask[{1'b0, idx4}];
  assign op_b = mask[{1'b1, idx4}];
  assign f3   = mask[{2'b00, idx3}];
endmodule

// File: rtl/ale_adder_pair.sv
module ale_adder_pair
  import ale_pkg::*;
(
  input  logic a0,
  input  logic b0,
  input  logic a1,
  input  logic b1,
  input  logic cin,
  output logic s0,
  output logic s1,
  output logic c_mid,
  output logic cout
);
  logic [1:0] r0, r1;
  assign r0    = full_add(a0, b0, cin);
  assign r1    = full_add(a1, b1, r0[1]);
  assign s0    = r0[0];
  assign c_mid = r0[1];
  assign s1    = r1[0];
  assign cout  = r1[1];
endmodule

// File: rtl/ale_out_reg.sv
module ale_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic use_chain,
  input  logic res,
  input  logic chain,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= 1'b0;
    else
      q <= use_chain ? chain : res;
  end
endmodule

// File: rtl/ale_cell.sv
module ale_cell
  import ale_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [DIN_W-1:0] d_in,
  input  logic             carry_in,
  output logic             carry_out,
  input  logic             share_in,
  output logic             share_out,
  input  logic             chain_in,
  output logic             chain_out,
  output logic             comb0,
  output logic             comb1,
  output logic             q0,
  output logic             q1
);
  localparam int NHALF = 2;

  logic [FRAME_W-1:0] frame_w;
  ale_cfg_t           cfg;
  ale_mode_e          mode_w;
  logic [OPT_W-1:0]   sel_w;
  logic               wide_w;

  ale_cfg_shift u_cfg (.clk(clk), .rst(rst), .en(cfg_en), .din(cfg_din), .frame(frame_w));

  assign cfg    = ale_cfg_t'(frame_w);
  assign mode_w = cfg.mode;
  assign sel_w  = cfg.opt;
  assign wide_w = cfg.opt[2];

  logic [HALF_W-1:0] mask_w [NHALF];
  logic [IDX5_W-1:0] idx5_w [NHALF];
  logic [IDX4_W-1:0] idx4_w [NHALF];
  logic [NHALF-1:0]  f5, op_a, op_b, f3;

  assign mask_w[0] = cfg.lo;
  assign mask_w[1] = cfg.hi;

  genvar gi;
  generate
    for (gi = 0; gi < NHALF; gi++) begin : g_half
      if (gi == 0) begin : g_idx_lo
        assign idx5_w[gi] = d_in[4:0];
        assign idx4_w[gi] = d_in[3:0];
      end else begin : g_idx_hi
        always_comb begin
          if (mode_w == MODE_EXT7)
            idx5_w[gi] = {d_in[6], d_in[3:0]};
          else if (wide_w)
            idx5_w[gi] = d_in[4:0];
          else
            idx5_w[gi] = d_in[7:3];
        end
        assign idx4_w[gi] = d_in[7:4];
      end
      ale_lut_half u_half (
        .mask(mask_w[gi]), .idx5(idx5_w[gi]), .idx4(idx4_w[gi]), .idx3(d_in[2:0]),
        .f5(f5[gi]), .op_a(op_a[gi]), .op_b(op_b[gi]), .f3(f3[gi])
      );
    end
  endgenerate

  // adder operands: shared mode feeds the sum term and the neighbour's carry
  logic is_shared, cin_eff, add_a0, add_b0;
  logic add_s0, add_s1, add_cmid, add_cout;
  assign is_shared = (mode_w == MODE_SHARED);
  assign cin_eff   = carry_in | sel_w[3];
  assign add_a0    = is_shared ? f3[0]    : op_a[0];
  assign add_b0    = is_shared ? share_in : op_b[0];

  ale_adder_pair u_add (
    .a0(add_a0), .b0(add_b0), .a1(op_a[1]), .b1(op_b[1]), .cin(cin_eff),
    .s0(add_s0), .s1(add_s1), .c_mid(add_cmid), .cout(add_cout)
  );

  logic r0, r1, rco, rso;
  always_comb begin
    r0 = 1'b0; r1 = 1'b0; rco = 1'b0; rso = 1'b0;
    unique case (mode_w)
      MODE_SPLIT: begin
        if (wide_w) r0 = d_in[5] ? f5[1] : f5[0];
        else begin
          r0 = f5[0];
          r1 = f5[1];
        end
      end
      MODE_EXT7:  r0 = d_in[7] ? f5[1] : f5[0];
      MODE_ARITH: begin
        r0  = add_s0;
        r1  = add_s1;
        rco = add_cout;
      end
      MODE_SHARED: begin
        r0  = add_s0;
        r1  = f3[1];
        rco = add_cmid;
        rso = f3[1];
      end
      default: ;
    endcase
  end

  assign comb0     = r0  & ~cfg_en;
  assign comb1     = r1  & ~cfg_en;
  assign carry_out = rco & ~cfg_en;
  assign share_out = rso & ~cfg_en;

  logic [NHALF-1:0] q_w, res_w, chn_w;
  assign res_w = {comb1, comb0};
  assign chn_w = {q_w[0], chain_in};

  generate
    for (gi = 0; gi < NHALF; gi++) begin : g_reg
      ale_out_reg u_reg (
        .clk(clk), .rst(rst), .clr(cfg_en), .use_chain(sel_w[gi]),
        .res(res_w[gi]), .chain(chn_w[gi]), .q(q_w[gi])
      );
    end
  endgenerate

  assign q0        = q_w[0];
  assign q1        = q_w[1];
  assign chain_out = q_w[1];
endmodule

// File: rtl/ale_cell_chk.sv
module ale_cell_chk
  import ale_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input ale_mode_e        mode,
  input logic [OPT_W-1:0] sel,
  input logic [1:0]       op_a,
  input logic [1:0]       op_b,
  input logic             cin_eff,
  input logic             chain_in,
  input logic             comb0,
  input logic             comb1,
  input logic             carry_out,
  input logic             share_out,
  input logic             q0,
  input logic             q1
);
  logic [2:0] exp_sum;
  assign exp_sum = {2'b00, op_a[0]} + {2'b00, op_b[0]} + {2'b00, cin_eff}
                 + {1'b0, op_a[1], 1'b0} + {1'b0, op_b[1], 1'b0};

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (!comb0 && !comb1 && !carry_out && !share_out)); // R2

  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (!q0 && !q1)); // R2

  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && (mode == MODE_SPLIT || mode == MODE_EXT7)) |-> (!carry_out && !share_out)); // R9

  AST_ARITH_ADD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && mode == MODE_ARITH) |-> ({carry_out, comb1, comb0} == exp_sum)); // R6

  AST_Q0_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !sel[0]) |=> (q0 == $past(comb0))); // R10

  AST_Q1_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && sel[1]) |=> (q1 == $past(q0))); // R10

  AST_Q0_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && sel[0]) |=> (q0 == $past(chain_in))); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!q0 && !q1 && mode == MODE_SPLIT && sel == '0)); // R11
endmodule

bind ale_cell ale_cell_chk chk_i (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .mode(mode_w), .sel(sel_w),
  .op_a(op_a), .op_b(op_b), .cin_eff(cin_eff), .chain_in(chain_in),
  .comb0(comb0), .comb1(comb1), .carry_out(carry_out), .share_out(share_out),
  .q0(q0), .q1(q1)
);

// File: tb/ale_cell_tb.sv
module ale_cell_tb_top;
  logic       clk = 1'b0;
  logic       rst, cfg_en, cfg_din, carry_in, share_in, chain_in;
  logic [7:0] d_in;
  logic       carry_out, share_out, chain_out, comb0, comb1, q0, q1;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ale_cell dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .d_in(d_in),
    .carry_in(carry_in), .carry_out(carry_out), .share_in(share_in), .share_out(share_out),
    .chain_in(chain_in), .chain_out(chain_out), .comb0(comb0), .comb1(comb1),
    .q0(q0), .q1(q1)
  );

  // frame = {mode[1:0], opt[3:0], HI[31:0], LO[31:0]}
  function automatic logic [69:0] cfg_of(input int id);
    case (id)
      0: cfg_of = {2'b00, 4'b0000, 32'hF0F0_3C3C, 32'h6996_A5A5};
      1: cfg_of = {2'b00, 4'b0100, 32'h1234_5678, 32'h9ABC_DEF0};
      2: cfg_of = {2'b01, 4'b0000, 32'hDEAD_BEEF, 32'h0F1E_2D3C};
      3: cfg_of = {2'b10, 4'b0000, 32'hCCCC_AAAA, 32'hCCCC_AAAA};
      4: cfg_of = {2'b10, 4'b1000, 32'hCCCC_AAAA, 32'hCCCC_AAAA};
      5: cfg_of = {2'b11, 4'b0000, 32'h0000_00E8, 32'h0000_0096};
      default: cfg_of = {2'b11, 4'b1000, 32'h0000_00E8, 32'h0000_0096};
    endcase
  endfunction

  function automatic string tag_of(input int id);
    case (id)
      0: tag_of = "R3 R9";
      1: tag_of = "R4 R9";
      2: tag_of = "R5 R9";
      3: tag_of = "R6";
      4: tag_of = "R7";
      5: tag_of = "R8";
      default: tag_of = "R7 R8";
    endcase
  endfunction

  // reference: returns {carry_out, share_out, comb1, comb0}
  function automatic logic [3:0] ref_eval(input logic [69:0] f, input logic [7:0] d,
                                          input logic ci, input logic si);
    logic [1:0]  md;
    logic [3:0]  op;
    logic [31:0] lo, hi;
    logic [63:0] full;
    int          tot, ce;
    md = f[69:68]; op = f[67:64]; hi = f[63:32]; lo = f[31:0]; full = f[63:0];
    ce = (op[3] || ci) ? 1 : 0;
    ref_eval = 4'b0000;
    case (md)
      2'b00: if (op[2]) ref_eval[0] = full[d[5:0]];
             else ref_eval[1:0] = {hi[d[7:3]], lo[d[4:0]]};
      2'b01: ref_eval[0] = d[7] ? hi[{d[6], d[3:0]}] : lo[d[4:0]];
      2'b10: begin
        tot = int'(lo[d[3:0]]) + int'(lo[16 + d[3:0]]) + ce
            + 2 * (int'(hi[d[7:4]]) + int'(hi[16 + d[7:4]]));
        ref_eval = {tot[2], 1'b0, tot[1], tot[0]};
      end
      default: begin
        tot = int'(lo[d[2:0]]) + int'(si) + ce;
        ref_eval = {tot[1], hi[d[2:0]], hi[d[2:0]], tot[0]};
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_cfg(input logic [69:0] f);
    for (int i = 69; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_din = f[i];
      if (i == 30) begin
        #1 check("R2 outputs quiet while loading",
                 {4'b0, carry_out, share_out, comb1, comb0}, 8'h00);
      end
    end
    @(negedge clk);
    cfg_en = 1'b0; cfg_din = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] id;
    logic [7:0] d;
    logic       ci;
    logic       si;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'h00, 1'b1, 1'b1}, '{3'd0, 8'hFF, 1'b1, 1'b0},
    '{3'd0, 8'h5A, 1'b0, 1'b1}, '{3'd0, 8'hA7, 1'b1, 1'b1},
    '{3'd1, 8'h3F, 1'b0, 1'b0}, '{3'd1, 8'h21, 1'b1, 1'b1},
    '{3'd1, 8'hC5, 1'b0, 1'b0},
    '{3'd2, 8'h13, 1'b0, 1'b0}, '{3'd2, 8'h93, 1'b1, 1'b1},
    '{3'd2, 8'hC9, 1'b0, 1'b0}, '{3'd2, 8'h4E, 1'b0, 1'b1},
    '{3'd3, 8'h33, 1'b1, 1'b1}, '{3'd3, 8'h00, 1'b1, 1'b0},
    '{3'd3, 8'h22, 1'b0, 1'b0},
    '{3'd4, 8'h00, 1'b0, 1'b0}, '{3'd4, 8'h33, 1'b0, 1'b1},
    '{3'd5, 8'h07, 1'b0, 1'b0}, '{3'd5, 8'h03, 1'b1, 1'b1},
    '{3'd5, 8'h04, 1'b0, 1'b1},
    '{3'd6, 8'h00, 1'b0, 1'b1}, '{3'd6, 8'h05, 1'b0, 1'b0},
    '{3'd6, 8'h07, 1'b1, 1'b1}
  };

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0; d_in = 8'h00;
    carry_in = 1'b0; share_in = 1'b0; chain_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R11 reset state", {1'b0, carry_out, share_out, comb1, comb0, q0, q1, chain_out}, 8'h00);

    // R1: mode 01, LO bit0 set only; d7 chooses the upper half
    load_cfg({2'b01, 4'b0000, 32'h0000_0000, 32'h0000_0001});
    d_in = 8'h00;
    #1 check("R1 frame order, lower half", {7'b0, comb0}, 8'h01);
    @(negedge clk); d_in = 8'h80;
    #1 check("R1 frame order, upper half", {7'b0, comb0}, 8'h00);

    begin : table_walk
      int cur = -1;
      for (int v = 0; v < NV; v++) begin
        if (int'(VEC[v].id) != cur) begin
          cur = int'(VEC[v].id);
          load_cfg(cfg_of(cur));
        end
        @(negedge clk);
        d_in = VEC[v].d; carry_in = VEC[v].ci; share_in = VEC[v].si;
        #1 check(tag_of(cur), {4'b0, carry_out, share_out, comb1, comb0},
                 {4'b0, ref_eval(cfg_of(cur), VEC[v].d, VEC[v].ci, VEC[v].si)});
      end
    end

    // R10: registers follow the combinational results
    load_cfg(cfg_of(0));
    #1 check("R2 registers cleared by loading", {6'b0, q1, q0}, 8'h00);
    d_in = 8'h5A;
    @(negedge clk);
    #1 check("R10 registers capture results", {6'b0, q1, q0},
             {6'b0, ref_eval(cfg_of(0), 8'h5A, 1'b0, 1'b0)});
    d_in = 8'hA7;
    @(negedge clk);
    #1 check("R10 registers capture results", {6'b0, q1, q0},
             {6'b0, ref_eval(cfg_of(0), 8'hA7, 1'b0, 1'b0)});

    // R10: register chain shifting
    load_cfg({2'b00, 4'b0011, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    chain_in = 1'b1;
    @(negedge clk);
    #1 check("R10 chain step 1", {5'b0, chain_out, q1, q0}, 8'b0000_0001);
    chain_in = 1'b0;
    @(negedge clk);
    #1 check("R10 chain step 2", {5'b0, chain_out, q1, q0}, 8'b0000_0110);
    @(negedge clk);
    #1 check("R10 chain step 3", {5'b0, chain_out, q1, q0}, 8'b0000_0000);

    // R11: reset wipes a loaded configuration
    load_cfg({2'b00, 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    d_in = 8'h11;
    @(negedge clk);
    #1 check("R11 before reset", {6'b0, q1, q0}, 8'h03);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R11 reset clears config and registers",
             {4'b0, comb1, comb0, q1, q0}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule